// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. A start pulse loads a control word, a source address, a destination address and a unit count. The channel then waits for its request source to ask for a unit. It arbitrates for the system bus and runs the read and write cycles for that unit on a memory-style master port. It steps the addresses and counts down to the end.

The control word selects several things:
- the address stepping for each side;
- the unit size;
- where requests come from: an active-low external line, an always-on auto request, or one of eight peripheral request lines;
- whether the external line is sensed by level or by falling edge;
- whether the bus is given back after every unit or held for the block;
- whether completion raises an interrupt.

Bad settings and misaligned start addresses are refused before any bus activity.

The master port uses a valid/ready handshake with back-pressure from the slave. Once `mem_valid` is high, the channel holds it high and keeps `mem_addr`, `mem_we`, `mem_size`, `mem_wdata` and `dack` unchanged until a cycle in which `mem_ready` is high. That cycle completes the bus cycle. The slave may hold `mem_ready` low for any number of cycles. Data on `mem_rdata` and `mem_wdata` is right-justified: a byte sits in bits 7:0 and a word in bits 15:0. The channel drives `mem_valid` only while it holds `bus_req`. It starts its first bus cycle only after it has seen `bus_gnt` high in the arbitration state.

Top module: `dma_chan`

## Requirements
- R1: After reset `busy`, `done`, `addr_err`, `irq`, `bus_req`, `mem_valid` and `dack` are all low.
- R2: The control word fields are:
  - bits 1:0: source step mode;
  - bits 3:2: destination step mode;
  - bits 5:4: size;
  - bits 9:6: request source;
  - bit 10: sense;
  - bit 11: burst;
  - bit 12: interrupt enable.

  A start carrying any of the following sets `addr_err`: step mode 11, size 11, source code 0001, 0101, 1110 or 1111, or a zero count. The channel then stays idle with no bus request.
- R3: A word unit (size 01) needs both start addresses even. A longword unit (size 10) needs both start addresses with bits 1:0 clear. A misaligned start sets `addr_err` with no bus activity. Byte units (size 00) accept any address.
- R4: Step mode 00 keeps an address fixed, 01 adds the unit size in bytes after each unit, and 10 subtracts it. The unit sizes are 1 for size 00, 2 for size 01 and 4 for size 10.
- R5: Source codes 0000, 0100 and 0110–1101 run dual-address units. Each such unit is a read at the source address followed by a write of the same data at the destination address. `mem_size` carries the size code.
- R6: Source code 0010 runs each unit as one read cycle at the source address with `dack` high. Code 0011 runs each unit as one write cycle at the destination address with `dack` high.
- R7: Source codes select the request as follows:
  - 0000, 0010 and 0011 use the external line `ext_req_n`;
  - 0100 requests continuously;
  - a code c in 0110–1101 uses `periph_req[c-6]`, active high.

  No other peripheral line has any effect.
- R8: With sense 0 the external request is active while `ext_req_n` is low. With sense 1 each falling edge seen while the channel is busy grants exactly one unit, however long the line stays low. Edges seen while idle are discarded.
- R9: With burst 0, `bus_req` falls after every unit and rises again for the next.
- R10: With burst 1, `bus_req` stays high from the first unit to the last. The exception is a level-sensed request that is absent when a unit ends; the bus is then released and requested again later.
- R11: The count falls by one per unit. After the last unit, `done` rises, `busy` falls and no further bus cycle occurs.
- R12: With interrupt enable 1, `irq` rises together with `done`. With 0, `irq` stays low. A new start clears `done`, `irq` and `addr_err`.
- R13: While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_addr` and `mem_we` hold. `mem_valid` is only high while `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the settings and arm the channel (ignored while busy) |
| ctl | input | 13 | Control word |
| src_init | input | AW | Starting source address |
| dst_init | input | AW | Starting destination address |
| cnt_init | input | CW | Number of units |
| ext_req_n | input | 1 | External request, active low |
| periph_req | input | 8 | Peripheral request lines |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Bus cycle valid |
| mem_ready | input | 1 | Slave completes the cycle |
| mem_we | output | 1 | 1 = write cycle |
| mem_size | output | 2 | Size code of the cycle |
| mem_addr | output | AW | Cycle address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| dack | output | 1 | Device acknowledge for single-address cycles |
| busy | output | 1 | Channel armed or transferring |
| done | output | 1 | Transfer end flag |
| addr_err | output | 1 | Settings refused |
| irq | output | 1 | Completion interrupt |

## Verification
The acceptance of the final write and a fresh falling edge on the external request can land on the same clock edge in edge-sensed mode. The bench provokes this from its bus responder: it lowers the request line in the half cycle just before it raises `mem_ready` for the last write. The outcome is judged by three facts. `done` rises. No fifth bus cycle appears. A following start with the line left low waits until a genuinely new edge arrives, and only then moves its single unit.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CTL_W    = 13;
  localparam int DW       = 32;
  localparam int N_PERIPH = 8;
  localparam int PIDX_W   = $clog2(N_PERIPH);

  typedef enum logic [1:0] {AM_FIX = 2'b00, AM_INC = 2'b01, AM_DEC = 2'b10, AM_BAD = 2'b11} amode_t;
  typedef enum logic [1:0] {SZ_B = 2'b00, SZ_W = 2'b01, SZ_L = 2'b10, SZ_BAD = 2'b11} usize_t;
  typedef enum logic [2:0] {RQ_EXT_DUAL, RQ_EXT_M2D, RQ_EXT_D2M, RQ_AUTO, RQ_PERIPH, RQ_BAD} rsrc_t;
  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_ARB, ST_RD, ST_WR, ST_SGL} st_t;

  typedef struct packed {
    amode_t            smode;
    amode_t            dmode;
    usize_t            size;
    rsrc_t             kind;
    logic [PIDX_W-1:0] pidx;
    logic              edge_mode;
    logic              burst;
    logic              ie;
  } cfg_t;

  function automatic logic [2:0] size_bytes(usize_t s);
    case (s)
      SZ_W:    return 3'd2;
      SZ_L:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic [CTL_W-1:0] ctl,
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    dst,
  input  logic [CW-1:0]    cnt,
  output cfg_t             cfg,
  output logic             legal
);
  logic [3:0] rs;
  logic [1:0] amask;

  always_comb begin
    rs            = ctl[9:6];
    cfg.smode     = amode_t'(ctl[1:0]);
    cfg.dmode     = amode_t'(ctl[3:2]);
    cfg.size      = usize_t'(ctl[5:4]);
    cfg.edge_mode = ctl[10];
    cfg.burst     = ctl[11];
    cfg.ie        = ctl[12];
    cfg.pidx      = '0;
    case (rs)
      4'b0000: cfg.kind = RQ_EXT_DUAL;
      4'b0010: cfg.kind = RQ_EXT_M2D;
      4'b0011: cfg.kind = RQ_EXT_D2M;
      4'b0100: cfg.kind = RQ_AUTO;
      4'b0110, 4'b0111, 4'b1000, 4'b1001,
      4'b1010, 4'b1011, 4'b1100, 4'b1101: begin
        cfg.kind = RQ_PERIPH;
        cfg.pidx = PIDX_W'(rs - 4'd6);
      end
      default: cfg.kind = RQ_BAD;
    endcase
    case (cfg.size)
      SZ_W:    amask = 2'b01;
      SZ_L:    amask = 2'b11;
      default: amask = 2'b00;
    endcase
    legal = (cfg.smode != AM_BAD) && (cfg.dmode != AM_BAD) &&
            (cfg.size != SZ_BAD) && (cfg.kind != RQ_BAD) && (cnt != '0) &&
            ((src[1:0] & amask) == 2'b00) && ((dst[1:0] & amask) == 2'b00);
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init,
  input  logic          adv,
  input  amode_t        mode,
  input  usize_t        size,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] step;
  assign step = AW'(size_bytes(size));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= init;
    end else if (adv) begin
      case (mode)
        AM_INC:  addr <= addr + step;
        AM_DEC:  addr <= addr - step;
        default: addr <= addr;
      endcase
    end
  end
endmodule

// File: rtl/dma_req_sense.sv
module dma_req_sense
  import dma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  cfg_t                cfg,
  input  logic                ext_req_n,
  input  logic [N_PERIPH-1:0] periph_req,
  input  logic                consume,
  output logic                req_now,
  output logic                keep_bus
);
  logic prev_n, edge_flag, fall, is_ext;

  assign fall   = prev_n & ~ext_req_n;
  assign is_ext = (cfg.kind == RQ_EXT_DUAL) || (cfg.kind == RQ_EXT_M2D) ||
                  (cfg.kind == RQ_EXT_D2M);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_n    <= 1'b1;
      edge_flag <= 1'b0;
    end else begin
      prev_n <= ext_req_n;
      if (!active) edge_flag <= 1'b0;
      else         edge_flag <= fall | (edge_flag & ~consume);
    end
  end

  always_comb begin
    case (cfg.kind)
      RQ_AUTO:   req_now = 1'b1;
      RQ_PERIPH: req_now = periph_req[cfg.pidx];
      RQ_EXT_DUAL, RQ_EXT_M2D, RQ_EXT_D2M:
                 req_now = cfg.edge_mode ? edge_flag : ~ext_req_n;
      default:   req_now = 1'b0;
    endcase
    keep_bus = (is_ext && cfg.edge_mode) ? 1'b1 : req_now;
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CTL_W-1:0]    ctl,
  input  logic [AW-1:0]       src_init,
  input  logic [AW-1:0]       dst_init,
  input  logic [CW-1:0]       cnt_init,
  input  logic                ext_req_n,
  input  logic [N_PERIPH-1:0] periph_req,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [1:0]          mem_size,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic                dack,
  output logic                busy,
  output logic                done,
  output logic                addr_err,
  output logic                irq
);
  st_t           st_q, st_d, first_st;
  cfg_t          cfg_d, cfg_q;
  logic          legal, load, unit_end, last, consume, req_now, keep_bus;
  logic          single, d2m;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q;
  logic [AW-1:0] addr_q [2];
  logic [AW-1:0] src_a, dst_a;

  dma_cfg_decode #(.AW(AW), .CW(CW)) u_dec (
    .ctl(ctl), .src(src_init), .dst(dst_init), .cnt(cnt_init),
    .cfg(cfg_d), .legal(legal)
  );

  assign load     = start && (st_q == ST_IDLE) && legal;
  assign unit_end = mem_valid && mem_ready && ((st_q == ST_WR) || (st_q == ST_SGL));
  assign last     = (cnt_q == CW'(1));
  assign consume  = (st_q == ST_WAIT) && req_now;
  assign single   = (cfg_q.kind == RQ_EXT_M2D) || (cfg_q.kind == RQ_EXT_D2M);
  assign d2m      = (cfg_q.kind == RQ_EXT_D2M);
  assign first_st = single ? ST_SGL : ST_RD;

  for (genvar i = 0; i < 2; i++) begin : g_addr
    dma_addr_step #(.AW(AW)) u_step (
      .clk(clk), .rst_n(rst_n), .load(load),
      .init(i == 0 ? src_init : dst_init),
      .adv(unit_end),
      .mode(i == 0 ? cfg_q.smode : cfg_q.dmode),
      .size(cfg_q.size),
      .addr(addr_q[i])
    );
  end
  assign src_a = addr_q[0];
  assign dst_a = addr_q[1];

  dma_req_sense u_req (
    .clk(clk), .rst_n(rst_n), .active(st_q != ST_IDLE), .cfg(cfg_q),
    .ext_req_n(ext_req_n), .periph_req(periph_req), .consume(consume),
    .req_now(req_now), .keep_bus(keep_bus)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start && legal) st_d = ST_WAIT;
      ST_WAIT: if (req_now) st_d = ST_ARB;
      ST_ARB:  if (bus_gnt) st_d = first_st;
      ST_RD:   if (mem_ready) st_d = ST_WR;
      ST_WR, ST_SGL:
        if (mem_ready) begin
          if (last)                           st_d = ST_IDLE;
          else if (cfg_q.burst && keep_bus)   st_d = first_st;
          else                                st_d = ST_WAIT;
        end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cfg_q    <= '0;
      cnt_q    <= '0;
      hold_q   <= '0;
      done     <= 1'b0;
      addr_err <= 1'b0;
      irq      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start && (st_q == ST_IDLE)) begin
        done     <= 1'b0;
        irq      <= 1'b0;
        addr_err <= ~legal;
      end
      if (load) begin
        cfg_q <= cfg_d;
        cnt_q <= cnt_init;
      end
      if ((st_q == ST_RD) && mem_ready) hold_q <= mem_rdata;
      if (unit_end) begin
        cnt_q <= cnt_q - CW'(1);
        if (last) begin
          done <= 1'b1;
          irq  <= cfg_q.ie;
        end
      end
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign bus_req   = (st_q == ST_ARB) || (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_SGL);
  assign mem_valid = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_SGL);
  assign mem_we    = (st_q == ST_WR) || ((st_q == ST_SGL) && d2m);
  assign mem_addr  = mem_we ? dst_a : src_a;
  assign mem_size  = cfg_q.size;
  assign mem_wdata = hold_q;
  assign dack      = (st_q == ST_SGL);

  // R13
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!bus_req && !mem_valid && !busy));
  // R11
  cnt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && cnt_q == '0));
  // R12
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  // R9
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && !cfg_q.burst) |=> !bus_req);
  // R10
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && cfg_q.burst && !last && keep_bus) |=> bus_req);
  // R4
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && cfg_q.smode == AM_INC) |=> (src_a == $past(src_a) + AW'(size_bytes(cfg_q.size))));
endmodule

// File: tb/dma_chan_tb_top.sv
module dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] ctl = '0;
  logic [31:0] src_init = '0, dst_init = '0;
  logic [15:0] cnt_init = '0;
  logic        ext_req_n = 1'b1;
  logic [7:0]  periph_req = '0;
  logic        bus_req, bus_gnt = 1'b0;
  logic        mem_valid, mem_ready = 1'b0, mem_we, dack, busy, done, addr_err, irq;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .src_init(src_init),
    .dst_init(dst_init), .cnt_init(cnt_init), .ext_req_n(ext_req_n),
    .periph_req(periph_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dack(dack), .busy(busy), .done(done),
    .addr_err(addr_err), .irq(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0]  mem [256];
  logic [7:0]  orig [256];
  logic [31:0] log_addr [32];
  logic        log_we [32];
  logic        log_dack [32];
  int n_log = 0, rises = 0, hs_viol = 0, lat = 0, wcnt = 0;
  logic breq_prev = 1'b0, pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic hook_drop = 1'b0, hook_edge = 1'b0;
  int   hook_n = 0;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // bus arbiter and slave model
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && (!mem_valid || mem_addr != pend_addr)) hs_viol++;
      if (mem_valid && !bus_gnt) hs_viol++;
      if (mem_ready) begin
        mem_ready = 1'b0; wcnt = 0; pend = 1'b0;
      end else if (mem_valid) begin
        if (wcnt >= lat) begin
          logic [7:0] a;
          a = mem_addr[7:0];
          mem_rdata = (mem_size == 2'b00) ? {24'h0, mem[a]} :
                      (mem_size == 2'b01) ? {16'h0, mem[8'(a+1)], mem[a]} :
                      {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
          if (mem_we && !dack) begin
            mem[a] = mem_wdata[7:0];
            if (mem_size != 2'b00) mem[8'(a+1)] = mem_wdata[15:8];
            if (mem_size == 2'b10) begin
              mem[8'(a+2)] = mem_wdata[23:16];
              mem[8'(a+3)] = mem_wdata[31:24];
            end
          end
          if (n_log < 32) begin
            log_addr[n_log] = mem_addr; log_we[n_log] = mem_we; log_dack[n_log] = dack;
          end
          if (hook_drop && mem_we) begin ext_req_n = 1'b1; hook_drop = 1'b0; end
          if (hook_edge && mem_we && n_log == hook_n) begin ext_req_n = 1'b0; hook_edge = 1'b0; end
          n_log++;
          mem_ready = 1'b1; pend = 1'b0;
        end else begin
          wcnt++; pend = 1'b1; pend_addr = mem_addr;
        end
      end
      if (bus_req && !breq_prev) rises++;
      breq_prev = bus_req;
      bus_gnt = bus_req;
    end
  end

  function automatic logic [12:0] mk(input logic [1:0] sm, input logic [1:0] dm, input logic [1:0] sz,
                                     input logic [3:0] rs, input logic ed, input logic bu, input logic ie);
    return {ie, bu, ed, rs, sz, dm, sm};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3); orig[i] = mem[i];
    end
  endtask

  task automatic kick(input logic [12:0] c, input logic [31:0] s, input logic [31:0] d, input logic [15:0] n);
    @(negedge clk);
    n_log = 0; rises = 0;
    ctl = c; src_init = s; dst_init = d; cnt_init = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    int c = 0;
    while (busy && c < maxc) begin @(negedge clk); c++; end
    chk(!busy, "R11 channel finished", busy, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !addr_err && !irq && !bus_req && !mem_valid && !dack, "R1 reset outputs",
        {busy, done, addr_err, irq, bus_req, mem_valid, dack}, 0);
  endtask

  task automatic t_dual_inc();
    logic ok = 1'b1;
    init_mem();
    kick(mk(2'b01, 2'b01, 2'b01, 4'b0100, 0, 0, 1), 32'h10, 32'h80, 3);
    wait_idle(200);
    for (int k = 0; k < 6; k++) if (mem[8'h80 + k] != orig[8'h10 + k]) ok = 1'b0;
    chk(ok, "R5 dual word data copied", ok, 1);
    chk(n_log == 6 && log_addr[0] == 32'h10 && log_addr[1] == 32'h80 && log_addr[4] == 32'h14 &&
        log_addr[5] == 32'h84 && !log_we[2] && log_we[3], "R4 word increment sequence", log_addr[4], 32'h14);
    chk(rises == 3, "R9 bus released per unit", rises, 3);
    chk(done && irq, "R12 irq with done", {done, irq}, 3);
  endtask

  task automatic t_burst_dec();
    logic ok = 1'b1;
    init_mem();
    kick(mk(2'b10, 2'b00, 2'b10, 4'b0100, 0, 1, 0), 32'h40, 32'hA0, 3);
    wait_idle(200);
    chk(n_log == 6 && log_addr[2] == 32'h3C && log_addr[4] == 32'h38 && log_addr[5] == 32'hA0,
        "R4 longword decrement, fixed destination", log_addr[4], 32'h38);
    for (int k = 0; k < 4; k++) if (mem[8'hA0 + k] != orig[8'h38 + k]) ok = 1'b0;
    chk(ok, "R5 last longword at fixed destination", ok, 1);
    chk(rises == 1, "R10 burst holds bus", rises, 1);
    chk(done && !irq, "R12 no irq when disabled", irq, 0);
  endtask

  task automatic t_byte_fixed();
    init_mem();
    kick(mk(2'b00, 2'b01, 2'b00, 4'b0100, 0, 0, 0), 32'h21, 32'hC1, 2);
    wait_idle(200);
    chk(!addr_err && n_log == 4 && log_addr[2] == 32'h21 && log_addr[3] == 32'hC2,
        "R3 R4 byte odd address, step one", log_addr[3], 32'hC2);
    chk(mem[8'hC1] == orig[8'h21] && mem[8'hC2] == orig[8'h21], "R5 byte data", mem[8'hC2], orig[8'h21]);
  endtask

  task automatic bad(input logic [12:0] c, input logic [31:0] s, input logic [31:0] d,
                     input logic [15:0] n, input string tag);
    kick(c, s, d, n);
    idle(12);
    chk(addr_err && !busy && n_log == 0 && rises == 0, tag, {addr_err, busy}, 2);
  endtask

  task automatic t_illegal();
    bad(mk(2'b01, 2'b01, 2'b11, 4'b0100, 0, 0, 0), 0, 32'h80, 2, "R2 size 11 refused");
    bad(mk(2'b11, 2'b01, 2'b00, 4'b0100, 0, 0, 0), 0, 32'h80, 2, "R2 source mode 11 refused");
    bad(mk(2'b01, 2'b11, 2'b00, 4'b0100, 0, 0, 0), 0, 32'h80, 2, "R2 destination mode 11 refused");
    bad(mk(2'b01, 2'b01, 2'b00, 4'b0001, 0, 0, 0), 0, 32'h80, 2, "R2 source code 0001 refused");
    bad(mk(2'b01, 2'b01, 2'b00, 4'b1110, 0, 0, 0), 0, 32'h80, 2, "R2 source code 1110 refused");
    bad(mk(2'b01, 2'b01, 2'b00, 4'b0100, 0, 0, 0), 0, 32'h80, 0, "R2 zero count refused");
    bad(mk(2'b01, 2'b01, 2'b01, 4'b0100, 0, 0, 0), 32'h11, 32'h80, 2, "R3 odd word source refused");
    bad(mk(2'b01, 2'b01, 2'b10, 4'b0100, 0, 0, 0), 0, 32'h82, 2, "R3 misaligned longword destination refused");
  endtask

  task automatic t_level();
    init_mem();
    ext_req_n = 1'b1;
    kick(mk(2'b01, 2'b01, 2'b00, 4'b0000, 0, 0, 0), 32'h50, 32'hD0, 2);
    idle(30);
    chk(busy && !addr_err && n_log == 0, "R8 level idle request waits", n_log, 0);
    ext_req_n = 1'b0;
    wait_idle(200);
    chk(done && n_log == 4 && mem[8'hD1] == orig[8'h51], "R8 level low moves units", n_log, 4);
    ext_req_n = 1'b1;
  endtask

  task automatic t_level_burst();
    init_mem();
    ext_req_n = 1'b0; hook_drop = 1'b1;
    kick(mk(2'b01, 2'b01, 2'b00, 4'b0000, 0, 1, 0), 32'h70, 32'hF0, 3);
    idle(30);
    chk(busy && !done && !bus_req && n_log == 2, "R10 burst released when level drops", n_log, 2);
    ext_req_n = 1'b0;
    wait_idle(200);
    chk(done && n_log == 6 && rises == 2, "R10 burst resumes and ends", rises, 2);
    ext_req_n = 1'b1;
  endtask

  task automatic t_edge();
    init_mem();
    ext_req_n = 1'b1;
    kick(mk(2'b01, 2'b01, 2'b00, 4'b0000, 1, 0, 0), 32'h60, 32'hE0, 2);
    idle(10);
    chk(n_log == 0, "R8 no edge no unit", n_log, 0);
    ext_req_n = 1'b0;
    idle(30);
    chk(busy && n_log == 2, "R8 one unit per edge while held low", n_log, 2);
    ext_req_n = 1'b1;
    idle(2);
    hook_n = 3; hook_edge = 1'b1;
    ext_req_n = 1'b0;
    @(negedge clk);
    ext_req_n = 1'b1;
    wait_idle(200);
    idle(20);
    chk(done && n_log == 4, "R11 edge at final write adds nothing", n_log, 4);
    kick(mk(2'b01, 2'b01, 2'b00, 4'b0000, 1, 0, 0), 32'h60, 32'hE0, 1);
    idle(20);
    chk(busy && n_log == 0, "R8 stale edge discarded", n_log, 0);
    ext_req_n = 1'b1;
    @(negedge clk);
    ext_req_n = 1'b0;
    wait_idle(200);
    chk(done && n_log == 2, "R8 fresh edge completes", n_log, 2);
    ext_req_n = 1'b1;
  endtask

  task automatic t_single();
    kick(mk(2'b01, 2'b00, 2'b01, 4'b0010, 0, 0, 0), 32'h30, 32'h0, 2);
    ext_req_n = 1'b0;
    wait_idle(200);
    chk(n_log == 2 && log_dack[0] && log_dack[1] && !log_we[0] && !log_we[1] &&
        log_addr[1] == 32'h32, "R6 single read cycles with dack", log_addr[1], 32'h32);
    kick(mk(2'b00, 2'b10, 2'b10, 4'b0011, 0, 0, 0), 32'h0, 32'h90, 2);
    wait_idle(200);
    chk(n_log == 2 && log_dack[0] && log_we[0] && log_we[1] && log_addr[0] == 32'h90 &&
        log_addr[1] == 32'h8C, "R6 single write cycles with dack", log_addr[1], 32'h8C);
    ext_req_n = 1'b1;
  endtask

  task automatic t_periph();
    init_mem();
    periph_req = 8'h00;
    kick(mk(2'b01, 2'b01, 2'b00, 4'b1011, 0, 0, 0), 32'h44, 32'hB0, 2);
    idle(20);
    chk(busy && n_log == 0, "R7 peripheral idle", n_log, 0);
    periph_req = 8'h10;
    idle(20);
    chk(busy && n_log == 0, "R7 other peripheral line ignored", n_log, 0);
    periph_req = 8'h20;
    wait_idle(200);
    chk(done && n_log == 4 && mem[8'hB1] == orig[8'h45], "R7 selected peripheral line serves", n_log, 4);
    periph_req = 8'h00;
  endtask

  task automatic t_backpressure();
    logic ok = 1'b1;
    init_mem();
    lat = 3; hs_viol = 0;
    kick(mk(2'b01, 2'b01, 2'b10, 4'b0100, 0, 1, 0), 32'h00, 32'h20, 2);
    wait_idle(400);
    for (int k = 0; k < 8; k++) if (mem[8'h20 + k] != orig[k]) ok = 1'b0;
    chk(ok, "R13 data correct under back-pressure", ok, 1);
    chk(hs_viol == 0, "R13 valid held until ready", hs_viol, 0);
    lat = 0;
  endtask

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dual_inc();
    t_burst_dec();
    t_byte_fixed();
    t_illegal();
    t_level();
    t_level_burst();
    t_edge();
    t_single();
    t_periph();
    t_backpressure();
    chk(hs_viol == 0, "R13 no handshake violations overall", hs_viol, 0);
    finish_run();
  end
endmodule